// File: doc/BRIEF.md
# Transmit Bit-Error Monitor

This block watches a serial transmitter on a link where the transmit and receive lines share one wire or are looped back. For each bit the transmitter drives, the monitor reads the receive line once, at a point inside the bit chosen by a 2-bit check-mode field, and compares the two levels. A difference raises a sticky error flag. The flag stays up until software pulses a clear strobe.

Time inside a bit is counted in 16x oversampling ticks. The transmitter marks the first tick of every bit with a start marker. The receive input first passes through a two-flop synchronizer, so the compared level is the one the line held two clocks before the sampling tick. An interrupt request follows the flag only while a separate enable bit is set.

Top module: `txbit_err_mon`

## Requirements
- R1: After reset, `err_flag` and `irq` are 0.
- R2: With `chk_mode` = 2'b00, no mismatch ever sets `err_flag`.
- R3: With `chk_mode` = 2'b01, the comparison is made at tick 9 of each bit.
- R4: With `chk_mode` = 2'b10, the comparison is made at tick 13 of each bit.
- R5: `chk_mode` = 2'b11 is treated the same as 2'b00, so no detection takes place.
- R6: A tick that arrives together with `bit_start` is tick 1 of a bit. Each later tick adds one, up to tick 16. Ticks after tick 16 that come without a new `bit_start` are never compared.
- R7: While `tx_active` is 0, no comparison is made and `err_flag` cannot be set.
- R8: A mismatch at the selected tick sets `err_flag`. The flag stays set until a cycle with `flag_clr` high and no new mismatch, after which it reads 0.
- R9: When `flag_clr` and a mismatch occur in the same cycle, `err_flag` stays set.
- R10: `rx_line` passes through two flops before the comparison. A level that first appears in the clock cycle of the selected tick is not the level compared.
- R11: `irq` is a level that equals `err_flag` AND `irq_en`, and it holds for as long as both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 16x oversampling strobe, one clock wide |
| bit_start | input | 1 | Marks the tick that is tick 1 of a transmitted bit |
| tx_active | input | 1 | High while the transmitter is shifting a frame |
| tx_bit | input | 1 | Level the transmitter is driving |
| rx_line | input | 1 | Receive line, asynchronous to clk |
| chk_mode | input | 2 | 00 off, 01 tick 9, 10 tick 13, 11 off |
| irq_en | input | 1 | Gates the error flag onto `irq` |
| flag_clr | input | 1 | One-clock strobe that clears the flag |
| err_flag | output | 1 | Sticky bit-error flag |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `tick` is a single-clock strobe, that `bit_start` only counts when it comes with a tick, and that `tx_bit` and `tx_active` stay constant across a bit. The bench drives one tick every four clocks and updates the transmit level, the receive level and `bit_start` only at slot boundaries. It moves the receive mismatch window between slots, so each window lands just before or on the sampling point of each mode. A behavioural model in the bench restates the synchronizer delay and the tick numbering and compares its results on every clock.

// File: rtl/txbm_pkg.sv
package txbm_pkg;

  typedef enum logic [1:0] {
    CHK_OFF  = 2'b00,
    CHK_MID  = 2'b01,
    CHK_LATE = 2'b10,
    CHK_RSVD = 2'b11
  } chk_mode_e;

  // Tick number at which a mode compares; 0 means no comparison.
  function automatic int unsigned pick_tick(input chk_mode_e m,
                                            input int unsigned t_mid,
                                            input int unsigned t_late);
    case (m)
      CHK_MID:  return t_mid;
      CHK_LATE: return t_late;
      default:  return 0;
    endcase
  endfunction

  // Tick number of the current tick, given the previous one; 0 = outside a bit.
  function automatic int unsigned next_tick(input logic start,
                                            input int unsigned prev,
                                            input int unsigned span);
    if (start) return 1;
    if (prev >= 1 && prev < span) return prev + 1;
    return 0;
  endfunction

endpackage

// File: rtl/txbm_sync.sv
module txbm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/txbm_bitpos.sv
module txbm_bitpos
  import txbm_pkg::*;
#(
  parameter int SPAN = 16,
  parameter int CW   = $clog2(SPAN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bit_start,
  output logic [CW-1:0] pos_now
);
  logic [CW-1:0] cnt;

  always_comb pos_now = CW'(next_tick(bit_start, 32'(cnt), SPAN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= pos_now;
  end

  AST_START_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && bit_start) |=> (cnt == CW'(1))); // R6

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bit_start && cnt >= CW'(1) && cnt < CW'(SPAN))
      |=> (cnt == $past(cnt) + CW'(1))); // R6
endmodule

// File: rtl/txbm_sticky.sv
module txbm_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/txbit_err_mon.sv
module txbit_err_mon
  import txbm_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int TICK_MID      = 9,
  parameter int TICK_LATE     = 13,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bit_start,
  input  logic       tx_active,
  input  logic       tx_bit,
  input  logic       rx_line,
  input  logic [1:0] chk_mode,
  input  logic       irq_en,
  input  logic       flag_clr,
  output logic       err_flag,
  output logic       irq
);
  localparam int CW = $clog2(TICKS_PER_BIT + 1);

  logic          rx_s;
  logic [CW-1:0] pos_now;
  int unsigned   sel_tick;
  logic          sample_evt;
  logic          mismatch_evt;

  txbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s));

  txbm_bitpos #(.SPAN(TICKS_PER_BIT), .CW(CW)) u_pos (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_start(bit_start),
    .pos_now(pos_now));

  always_comb begin
    sel_tick     = pick_tick(chk_mode_e'(chk_mode), TICK_MID, TICK_LATE);
    sample_evt   = tick && tx_active && (sel_tick != 0) && (32'(pos_now) == sel_tick);
    mismatch_evt = sample_evt && (rx_s != tx_bit);
  end

  txbm_sticky u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(mismatch_evt), .clr_i(flag_clr),
    .flag_o(err_flag));

  assign irq = err_flag & irq_en;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |=> err_flag); // R9

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !mismatch_evt) |=> !err_flag); // R8

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !flag_clr) |=> err_flag); // R8

  AST_OFF_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((chk_mode == 2'b00 || chk_mode == 2'b11) && !err_flag) |=> !err_flag); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !err_flag) |=> !err_flag); // R7
endmodule

// File: tb/tb_txbit_err_mon.sv
module tb_txbit_err_mon;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0;
  logic tick = 0, bit_start = 0, tx_active = 0, tx_bit = 1, rx_line = 1;
  logic [1:0] chk_mode = 2'b00;
  logic irq_en = 0, flag_clr = 0;
  logic err_flag, irq;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(PER/2) clk = ~clk;

  txbit_err_mon dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_start(bit_start),
    .tx_active(tx_active), .tx_bit(tx_bit), .rx_line(rx_line),
    .chk_mode(chk_mode), .irq_en(irq_en), .flag_clr(flag_clr),
    .err_flag(err_flag), .irq(irq));

  // Behavioural reference model
  logic rxq[$];
  int   m_pos;
  logic m_flag;

  always @(posedge clk or negedge rst_n) begin
    logic seen, hit;
    int sel;
    if (!rst_n) begin
      m_pos = 0; m_flag = 0; rxq = '{1'b1, 1'b1};
    end else begin
      seen = rxq.pop_front();
      rxq.push_back(rx_line);
      hit = 0;
      if (tick) begin
        if (bit_start) m_pos = 1;
        else if (m_pos >= 1 && m_pos < 16) m_pos++;
        else m_pos = 0;
        sel = (chk_mode == 2'b01) ? 9 : (chk_mode == 2'b10) ? 13 : 0;
        hit = tx_active && sel != 0 && m_pos == sel && seen !== tx_bit;
      end
      if (hit) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(cur_req, err_flag, m_flag, "model err_flag");
      check("R11", irq, m_flag & irq_en, "model irq");
    end
  end

  // One bit: 16 tick slots of 4 clocks; rx is wrong in slots lo..hi
  task automatic run_bit(input logic txb, input logic start_en, input logic act,
                         input int lo, input int hi, input int clr_slot);
    for (int s = 1; s <= 16; s++) begin
      @(negedge clk);
      tick = 1; bit_start = start_en && (s == 1);
      tx_bit = txb; tx_active = act;
      rx_line = (s >= lo && s <= hi) ? ~txb : txb;
      flag_clr = (s == clr_slot);
      @(negedge clk);
      tick = 0; bit_start = 0; flag_clr = 0;
      repeat (2) @(negedge clk);
    end
    @(negedge clk);
    rx_line = txb;
  endtask

  task automatic pulse_clear();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic expect_flag(input string req, input logic exp, input string what);
    @(negedge clk); #2;
    check(req, err_flag, exp, what);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PER * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1", err_flag, 1'b0, "flag in reset");
    check("R1", irq, 1'b0, "irq in reset");
    rst_n = 1;
    expect_flag("R1", 1'b0, "flag after reset");

    cur_req = "R2"; chk_mode = 2'b00;
    run_bit(1'b0, 1, 1, 1, 16, 0);
    expect_flag("R2", 1'b0, "mode 00 full mismatch");

    cur_req = "R5"; chk_mode = 2'b11;
    run_bit(1'b1, 1, 1, 1, 16, 0);
    expect_flag("R5", 1'b0, "mode 11 full mismatch");

    cur_req = "R3"; chk_mode = 2'b01;
    run_bit(1'b0, 1, 1, 8, 8, 0);
    expect_flag("R3", 1'b1, "mode 01 mismatch before tick 9");
    cur_req = "R8";
    run_bit(1'b1, 1, 1, 0, 0, 0);
    expect_flag("R8", 1'b1, "flag sticky over clean bit");
    pulse_clear();
    expect_flag("R8", 1'b0, "flag cleared");

    cur_req = "R3";
    run_bit(1'b1, 1, 1, 12, 12, 0);
    expect_flag("R3", 1'b0, "mode 01 ignores tick 13 window");

    cur_req = "R4"; chk_mode = 2'b10;
    run_bit(1'b0, 1, 1, 12, 12, 0);
    expect_flag("R4", 1'b1, "mode 10 mismatch before tick 13");
    pulse_clear();
    run_bit(1'b0, 1, 1, 8, 8, 0);
    expect_flag("R4", 1'b0, "mode 10 ignores tick 9 window");

    cur_req = "R10"; chk_mode = 2'b01;
    run_bit(1'b1, 1, 1, 9, 9, 0);
    expect_flag("R10", 1'b0, "late rx change hidden by synchronizer");

    cur_req = "R7";
    run_bit(1'b0, 1, 0, 1, 16, 0);
    expect_flag("R7", 1'b0, "no compare while idle");

    cur_req = "R6";
    run_bit(1'b0, 0, 1, 1, 16, 0);
    expect_flag("R6", 1'b0, "ticks past 16 without start");
    run_bit(1'b1, 1, 1, 0, 0, 0);
    run_bit(1'b1, 0, 1, 1, 16, 0);
    expect_flag("R6", 1'b0, "run-on after full bit not compared");
    run_bit(1'b0, 1, 1, 8, 8, 0);
    expect_flag("R6", 1'b1, "realigned on bit_start");

    cur_req = "R11";
    irq_en = 0; @(negedge clk); #2;
    check("R11", irq, 1'b0, "irq masked");
    irq_en = 1; @(negedge clk); #2;
    check("R11", irq, 1'b1, "irq raised");
    repeat (5) @(negedge clk); #2;
    check("R11", irq, 1'b1, "irq held as level");
    pulse_clear();
    expect_flag("R11", 1'b0, "flag cleared");
    check("R11", irq, 1'b0, "irq dropped after clear");

    cur_req = "R9";
    run_bit(1'b1, 1, 1, 8, 8, 9);
    expect_flag("R9", 1'b1, "set beats simultaneous clear from 0");
    run_bit(1'b0, 1, 1, 8, 8, 9);
    expect_flag("R9", 1'b1, "set beats simultaneous clear from 1");
    check("R11", irq, 1'b1, "irq follows flag");

    done = 1;
    summary();
  end
endmodule